// File: doc/BRIEF.md
# Buffered Single-Channel PWM Timer

This block is a pulse-width modulation timer with one output channel. A programmable clock divider produces count ticks. A counter steps once per tick, either upward from zero to a period limit or downward from that limit to zero. A compare stage sets a reference level from the counter value and a compare threshold, and an output stage applies polarity inversion and channel gating before the level reaches the pin.

The period limit and the compare threshold each have two copies: a working value and a staged value. When staging is enabled for a register, a write goes only to its staged copy. The working copy takes that value at the next update event. An update event is either the counter's natural wrap or reload, or a software strobe. When staging is disabled, a write reaches the working copy in the next cycle. Every update event raises a one-clock pulse on a dedicated output.

Configuration comes in as plain level inputs plus write strobes for the divider, period and compare values. The pin level is combinational from registered state, so it follows the counter in the same cycle.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset the working period limit is all ones, the compare threshold is 0, the divider setting is 0, the counter is 0 and `update_pulse` is low. With the channel enabled, no inversion, upward counting and lead mode, the pin is low. In trail mode it is high.
- R2: While `run` is high, the counter changes once every `psc_wdata`+1 clock cycles, using the last divider value written. An upward period therefore lasts (period+1)·(divider+1) clocks.
- R3: When counting up, the counter runs from 0 to the working period limit and then returns to 0. That return is an update event, and `update_pulse` is high in the first cycle in which the counter shows 0. Example: with period 8, compare 4, lead mode and divider 0, the pin is high for 4 of every 9 cycles.
- R4: When counting down (`count_down`=1), the counter runs from its value down to 0 and then reloads with the staged period limit. That reload is an update event.
- R5: `cmp_mode`=0 (lead) counting up: the reference is active while count < compare. Counting down: it is active while count <= compare. `cmp_mode`=1 (trail) gives the inverse of lead in both directions. In lead mode counting up, a compare value above the period keeps the reference active for the whole period, and a compare value of 0 keeps it inactive for the whole period.
- R6: With `out_invert`=1, the pin shows the inverse of the reference. With `out_invert`=0, it shows the reference.
- R7: With `chan_en`=0, the pin is 0 whatever the mode, polarity and count.
- R8: With `period_buf_en` (or `cmp_buf_en`) set, a written value changes neither the wrap point (or the pin threshold) until the next update event. With it clear, the new value applies from the next cycle.
- R9: A high `sw_update` in a cycle copies both staged values into the working copies and clears the divider phase. It sets the counter to 0 when counting up, or to the staged period limit when counting down, and raises `update_pulse` in the next cycle. It has priority over a tick in the same cycle.
- R10: While `run` is low, the counter and divider phase hold, and no wrap event or update pulse arises from counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psc_wdata | input | PSC_W | Divider value (divide by value+1) |
| psc_we | input | 1 | Divider write strobe |
| period_wdata | input | CNT_W | Period limit write data |
| period_we | input | 1 | Period limit write strobe |
| cmp_wdata | input | CNT_W | Compare threshold write data |
| cmp_we | input | 1 | Compare threshold write strobe |
| cmp_mode | input | 1 | 0 lead mode, 1 trail mode |
| out_invert | input | 1 | 1 inverts the reference on the pin |
| period_buf_en | input | 1 | Stage period writes until an update event |
| cmp_buf_en | input | 1 | Stage compare writes until an update event |
| chan_en | input | 1 | Channel output enable |
| run | input | 1 | Counter enable |
| count_down | input | 1 | 1 counts down, 0 counts up |
| sw_update | input | 1 | Software update event strobe |
| pwm_out | output | 1 | PWM pin level |
| update_pulse | output | 1 | One-clock pulse per update event |

## Verification
The bench builds the timer with a 4-bit counter and a 2-bit divider. At that size it can sweep every period limit against every compare value, in both directions and both compare modes, with the divider and polarity varying from one combination to the next. The small widths make the edge cases short runs: compare above the period, compare at zero, a period of zero, and the full-scale reset period. Directed runs then cover staged writes landing mid-period, software updates during counting, stalls, and channel gating, all against an arithmetic model in the bench.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic {
    CMP_LEAD  = 1'b0,
    CMP_TRAIL = 1'b1
  } cmp_mode_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  // Reference level: lead mode is active below the threshold (inclusive when counting down).
  function automatic logic ref_active(input logic [31:0] cnt, input logic [31:0] cmp,
                                      input cnt_dir_e dir, input cmp_mode_e mode);
    logic below;
    below = (dir == DIR_DOWN) ? (cnt <= cmp) : (cnt < cmp);
    return (mode == CMP_TRAIL) ? !below : below;
  endfunction

  // Next counter value on a tick.
  function automatic logic [31:0] next_count(input logic [31:0] cnt, input logic [31:0] reload,
                                             input cnt_dir_e dir, input logic at_end);
    if (at_end) return (dir == DIR_DOWN) ? reload : 32'd0;
    return (dir == DIR_DOWN) ? cnt - 32'd1 : cnt + 32'd1;
  endfunction

endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  output logic             tick
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      psc_q <= '0;
    else if (psc_we) psc_q <= psc_wdata;
  end

  assign tick = run && (phase_q >= psc_q);

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (clr)  phase_q <= '0;
    else if (tick) phase_q <= '0;
    else if (run)  phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] act_q,
  output logic [W-1:0] buf_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= RST_VAL;
      buf_q <= RST_VAL;
    end else begin
      if (load) act_q <= buf_q;
      if (wr_en) begin
        buf_q <= wr_data;
        if (!buf_en) act_q <= wr_data;
      end
    end
  end
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         down,
  input  logic         sw_upd,
  input  logic [W-1:0] limit_act,
  input  logic [W-1:0] limit_load,
  output logic [W-1:0] cnt_q,
  output logic         wrap_evt
);
  cnt_dir_e dir;
  logic     at_end;

  assign dir      = cnt_dir_e'(down);
  assign at_end   = (dir == DIR_DOWN) ? (cnt_q == '0) : (cnt_q >= limit_act);
  assign wrap_evt = tick && !sw_upd && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (sw_upd) cnt_q <= (dir == DIR_DOWN) ? limit_load : '0;
    else if (tick)   cnt_q <= W'(next_count(32'(cnt_q), 32'(limit_load), dir, at_end));
  end
endmodule

// File: rtl/pwm_cmp_stage.sv
module pwm_cmp_stage
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] thresh,
  input  logic         down,
  input  logic         trail,
  input  logic         invert,
  input  logic         enable,
  output logic         ref_lvl,
  output logic         pin
);
  assign ref_lvl = ref_active(32'(cnt), 32'(thresh), cnt_dir_e'(down), cmp_mode_e'(trail));
  assign pin     = enable & (ref_lvl ^ invert);
endmodule

// File: rtl/pwm_timer_ch.sv
module pwm_timer_ch #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             psc_we,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             period_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             cmp_we,
  input  logic             cmp_mode,
  input  logic             out_invert,
  input  logic             period_buf_en,
  input  logic             cmp_buf_en,
  input  logic             chan_en,
  input  logic             run,
  input  logic             count_down,
  input  logic             sw_update,
  output logic             pwm_out,
  output logic             update_pulse
);
  localparam int               NSHADOW    = 2;
  localparam int               IDX_PERIOD = 0;
  localparam int               IDX_CMP    = 1;
  localparam logic [CNT_W-1:0] PERIOD_RST = {CNT_W{1'b1}};

  logic [NSHADOW-1:0][CNT_W-1:0] sh_wdata, sh_act, sh_buf;
  logic [NSHADOW-1:0]            sh_we, sh_bufen;

  logic [CNT_W-1:0] arr_act, arr_buf, ccr_act, cnt_q;
  logic             tick, wrap_evt, upd_evt, ref_lvl;

  assign sh_wdata[IDX_PERIOD] = period_wdata;
  assign sh_we[IDX_PERIOD]    = period_we;
  assign sh_bufen[IDX_PERIOD] = period_buf_en;
  assign sh_wdata[IDX_CMP]    = cmp_wdata;
  assign sh_we[IDX_CMP]       = cmp_we;
  assign sh_bufen[IDX_CMP]    = cmp_buf_en;

  assign upd_evt = sw_update | wrap_evt;

  for (genvar g = 0; g < NSHADOW; g++) begin : g_shadow
    pwm_shadow_reg #(
      .W      (CNT_W),
      .RST_VAL((g == IDX_PERIOD) ? PERIOD_RST : {CNT_W{1'b0}})
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .buf_en (sh_bufen[g]),
      .wr_en  (sh_we[g]),
      .wr_data(sh_wdata[g]),
      .load   (upd_evt),
      .act_q  (sh_act[g]),
      .buf_q  (sh_buf[g])
    );
  end

  assign arr_act = sh_act[IDX_PERIOD];
  assign arr_buf = sh_buf[IDX_PERIOD];
  assign ccr_act = sh_act[IDX_CMP];

  pwm_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clr      (sw_update),
    .psc_we   (psc_we),
    .psc_wdata(psc_wdata),
    .tick     (tick)
  );

  pwm_count_core #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .down      (count_down),
    .sw_upd    (sw_update),
    .limit_act (arr_act),
    .limit_load(arr_buf),
    .cnt_q     (cnt_q),
    .wrap_evt  (wrap_evt)
  );

  pwm_cmp_stage #(.W(CNT_W)) u_cmp (
    .cnt    (cnt_q),
    .thresh (ccr_act),
    .down   (count_down),
    .trail  (cmp_mode),
    .invert (out_invert),
    .enable (chan_en),
    .ref_lvl(ref_lvl),
    .pin    (pwm_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) update_pulse <= 1'b0;
    else        update_pulse <= upd_evt;
  end
endmodule

// File: rtl/pwm_timer_ch_chk.sv
module pwm_timer_ch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             down,
  input logic             sw_update,
  input logic             cmp_buf_en,
  input logic             tick,
  input logic             upd_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr_act,
  input logic [CNT_W-1:0] arr_buf,
  input logic [CNT_W-1:0] ccr_act,
  input logic             update_pulse
);
  p_upstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && !sw_update && cnt < arr_act) |=> cnt == $past(cnt) + 1'b1);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && !sw_update && cnt >= arr_act) |=> (cnt == '0) && update_pulse);

  p_downstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && !sw_update && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && !sw_update && cnt == '0) |=> (cnt == $past(arr_buf)) && update_pulse);

  p_pulse_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> !update_pulse);

  p_cmp_staged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_buf_en && !upd_evt) |=> $stable(ccr_act));

  p_sw_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_update && !down) |=> (cnt == '0) && update_pulse);

  p_sw_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_update && down) |=> (cnt == $past(arr_buf)) && update_pulse);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_update) |=> $stable(cnt) && !update_pulse);
endmodule

bind pwm_timer_ch pwm_timer_ch_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .down        (count_down),
  .sw_update   (sw_update),
  .cmp_buf_en  (cmp_buf_en),
  .tick        (tick),
  .upd_evt     (upd_evt),
  .cnt         (cnt_q),
  .arr_act     (arr_act),
  .arr_buf     (arr_buf),
  .ccr_act     (ccr_act),
  .update_pulse(update_pulse)
);

// File: tb/pwm_timer_ch_tb_top.sv
module pwm_timer_ch_tb_top;
  localparam int CW = 4;
  localparam int PW = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] psc_wdata = '0;
  logic psc_we = 1'b0;
  logic [CW-1:0] period_wdata = '0;
  logic period_we = 1'b0;
  logic [CW-1:0] cmp_wdata = '0;
  logic cmp_we = 1'b0;
  logic cmp_mode = 1'b0, out_invert = 1'b0, period_buf_en = 1'b0, cmp_buf_en = 1'b0;
  logic chan_en = 1'b0, run = 1'b0, count_down = 1'b0, sw_update = 1'b0;
  logic pwm_out, update_pulse;

  always #10 clk = ~clk;

  pwm_timer_ch #(.CNT_W(CW), .PSC_W(PW)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur = "R5";

  // bench model state
  int m_psc, m_phase, m_cnt, m_arr_a, m_arr_b, m_ccr_a, m_ccr_b;
  bit m_upd;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_pin();
    bit lvl;
    if (!chan_en) return 0;
    if (count_down) lvl = !(m_cnt > m_ccr_a);
    else            lvl = (m_cnt < m_ccr_a);
    if (cmp_mode)   lvl = !lvl;
    if (out_invert) lvl = !lvl;
    return int'(lvl);
  endfunction

  task automatic model_reset();
    m_psc = 0; m_phase = 0; m_cnt = 0; m_arr_a = CMAX; m_arr_b = CMAX;
    m_ccr_a = 0; m_ccr_b = 0; m_upd = 0;
  endtask

  task automatic model_advance();
    bit t, evt;
    int ncnt, nph;
    t = run && (m_phase >= m_psc);
    evt = 0; ncnt = m_cnt; nph = m_phase;
    if (sw_update) nph = 0;
    else if (t) nph = 0;
    else if (run) nph = m_phase + 1;
    if (sw_update) begin
      ncnt = count_down ? m_arr_b : 0; evt = 1;
    end else if (t) begin
      if (!count_down) begin
        if (m_cnt >= m_arr_a) begin ncnt = 0; evt = 1; end
        else ncnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin ncnt = m_arr_b; evt = 1; end
        else ncnt = m_cnt - 1;
      end
    end
    if (evt) begin m_arr_a = m_arr_b; m_ccr_a = m_ccr_b; end
    if (period_we) begin m_arr_b = int'(period_wdata); if (!period_buf_en) m_arr_a = int'(period_wdata); end
    if (cmp_we) begin m_ccr_b = int'(cmp_wdata); if (!cmp_buf_en) m_ccr_a = int'(cmp_wdata); end
    if (psc_we) m_psc = int'(psc_wdata);
    m_cnt = ncnt; m_phase = nph; m_upd = evt;
  endtask

  task automatic step();
    model_advance();
    @(posedge clk);
    @(negedge clk);
    chk(pwm_out == exp_pin(), cur, "pwm_out", int'(pwm_out), exp_pin());
    chk(update_pulse == m_upd, cur, "update_pulse", int'(update_pulse), int'(m_upd));
    psc_we = 0; period_we = 0; cmp_we = 0; sw_update = 0;
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // write all three values unstaged, then force an update to start a clean period
  task automatic setup(input int arr, input int ccr, input int psc);
    period_buf_en = 0; cmp_buf_en = 0;
    period_wdata = CW'(arr); period_we = 1;
    cmp_wdata = CW'(ccr); cmp_we = 1;
    psc_wdata = PW'(psc); psc_we = 1;
    step();
    sw_update = 1;
    step();
  endtask

  initial begin
    #(20 * 190000);
    chk(0, "R10", "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int hi, np, gap;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chan_en = 1;
    #1;
    chk(pwm_out == 1'b0, "R1", "pin lead after reset", int'(pwm_out), 0);
    chk(update_pulse == 1'b0, "R1", "pulse after reset", int'(update_pulse), 0);
    cmp_mode = 1;
    #1;
    chk(pwm_out == 1'b1, "R1", "pin trail after reset", int'(pwm_out), 1);
    cmp_mode = 0;
    cur = "R1";
    run_n(3);

    // R3: period 8, compare 4, lead, up
    run = 1; cur = "R3";
    setup(8, 4, 0);
    hi = int'(pwm_out);
    for (int i = 0; i < 8; i++) begin step(); hi += int'(pwm_out); end
    chk(hi == 4, "R3", "high cycles per period", hi, 4);
    np = 0;
    for (int i = 0; i < 9; i++) begin step(); np += int'(update_pulse); end
    chk(np == 1, "R3", "pulses per period", np, 1);

    // R2: divider 2, period 3 -> 12 clocks per period
    cur = "R2";
    setup(3, 1, 2);
    gap = 0;
    for (int i = 0; i < 40; i++) begin
      step(); gap++;
      if (update_pulse) break;
    end
    chk(gap == 12, "R2", "clocks between updates", gap, 12);

    // R4: down count, period 5, compare 2
    cur = "R4"; count_down = 1;
    setup(5, 2, 0);
    hi = int'(pwm_out);
    for (int i = 0; i < 5; i++) begin step(); hi += int'(pwm_out); end
    chk(hi == 3, "R4", "active counts when down", hi, 3);
    step();
    chk(update_pulse == 1'b1, "R4", "reload pulse", int'(update_pulse), 1);
    run_n(12);
    count_down = 0;

    // R6: inverted polarity
    cur = "R6"; out_invert = 1;
    setup(6, 2, 1);
    run_n(30);
    out_invert = 0;

    // R7: channel disabled, compare above period in every mode and polarity
    cur = "R7"; chan_en = 0;
    setup(4, 9, 0);
    for (int k = 0; k < 4; k++) begin
      cmp_mode = k[0]; out_invert = k[1];
      run_n(6);
      chk(pwm_out == 1'b0, "R7", "pin while disabled", int'(pwm_out), 0);
    end
    chan_en = 1; cmp_mode = 0; out_invert = 0;

    // R8: staged writes land mid-period and wait for the wrap
    cur = "R8";
    setup(9, 3, 0);
    run_n(2);
    period_buf_en = 1; cmp_buf_en = 1;
    cmp_wdata = 4'd7; cmp_we = 1;
    period_wdata = 4'd5; period_we = 1;
    step();
    run_n(3);
    chk(pwm_out == 1'b0, "R8", "staged compare not yet active", int'(pwm_out), 0);
    run_n(25);
    // unstaged write applies at once
    period_buf_en = 0; cmp_buf_en = 0;
    cmp_wdata = 4'd0; cmp_we = 1;
    step();
    chk(pwm_out == 1'b0, "R8", "unstaged compare 0", int'(pwm_out), 0);
    run_n(10);
    // staged write coinciding with an update event from software
    cmp_buf_en = 1;
    cmp_wdata = 4'd2; cmp_we = 1; sw_update = 1;
    step();
    run_n(12);
    cmp_buf_en = 0;

    // R9: software update mid-count, both directions
    cur = "R9";
    setup(12, 6, 1);
    run_n(7);
    sw_update = 1;
    step();
    chk(update_pulse == 1'b1, "R9", "pulse after software update", int'(update_pulse), 1);
    run_n(5);
    count_down = 1;
    sw_update = 1;
    step();
    chk(pwm_out == 1'b0, "R9", "down restart at period", int'(pwm_out), 0);
    run_n(20);
    count_down = 0;

    // R10: stall holds count and suppresses pulses
    cur = "R10";
    setup(2, 1, 0);
    run = 0;
    np = 0;
    for (int i = 0; i < 8; i++) begin step(); np += int'(update_pulse); end
    chk(np == 0, "R10", "pulses while stalled", np, 0);
    run = 1;
    run_n(8);

    // R5: sweep of period x compare x direction x mode
    cur = "R5";
    for (int a = 0; a <= CMAX; a++) begin
      for (int c = 0; c <= CMAX; c++) begin
        for (int d = 0; d < 2; d++) begin
          for (int md = 0; md < 2; md++) begin
            int p;
            p = (a + c + d) % (1 << PW);
            count_down = d[0]; cmp_mode = md[0]; out_invert = c[1] ^ a[0];
            setup(a, c, p);
            run_n(2 * (a + 1) * (p + 1) + 1);
          end
        end
      end
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule